// File: doc/BRIEF.md
# Hotplug Event and Slot-Change Registers

This block holds the registers that firmware uses to learn about device insertion and removal in an expansion-slot fabric. It has a 16-bit event status register and a 16-bit event enable register, both reached one byte at a time. It also has two 32-bit slot-change masks, one for inserted slots and one for removed slots, and a write-only eject port. A hardware hotplug notification carries a slot number and a direction. When one arrives, the block records which slot changed and raises the hotplug status bit. If that bit's enable is set, it also gives a one-cycle interrupt pulse.

Software clears status by writing ones to it. It decides which slot changed by reading the two masks. To ask for a removal, it writes a bitmask to the eject port. The block turns that mask into the index of its lowest set bit and presents that index, for one cycle, to the logic that performs the removal.

Access uses a simple single-cycle register bus. `bus_sel` picks a window and `bus_addr` gives a byte offset inside it. Read data is combinational in the same cycle. Writes take effect at the clock edge.

Top module: `hpgpe_top`

## Requirements
- R1: After reset, status, enable and both slot masks read 0, and `sci_pulse` and `eject_valid` are low.
- R2: Window `bus_sel`=0 maps status bits 7:0 at offset 0 and bits 15:8 at offset 1, and enable bits 7:0 at offset 2 and bits 15:8 at offset 3. Reads return the byte in `bus_rdata[7:0]` with the upper bits zero. Offsets 4 to 7 read 0 and ignore writes, and window 3 behaves the same way.
- R3: A write to a status byte clears exactly the bits written as 1 in that byte. The other status byte and the enable register do not change.
- R4: A write to an enable byte replaces that byte only.
- R5: Window `bus_sel`=1 holds the inserted mask at offset 0 and the removed mask at offset 4. Both are 32-bit and can be read and written.
- R6: A hotplug event (`hp_valid`) clears both masks. It then sets bit `hp_slot` in the inserted mask when `hp_insert`=1, or in the removed mask when `hp_insert`=0.
- R7: A hotplug event sets status bit 1 at the same edge. If software writes to clear that bit in the same cycle, the set wins.
- R8: `sci_pulse` is high for exactly the one cycle after an event cycle in which enable bit 1 was already set. An enable write in the event cycle does not affect that event.
- R9: A write to window `bus_sel`=2, offset 0, with a nonzero value raises `eject_valid` for the next cycle. `eject_slot` then carries the index of the lowest set bit of the written value. A zero write gives no pulse.
- R10: Reads of the eject window return 0.
- R11: When a hotplug event and a write to a slot mask fall in the same cycle, the event's result is what gets stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_sel | input | 2 | Window: 0 event regs, 1 slot masks, 2 eject, 3 unused |
| bus_addr | input | 3 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| hp_valid | input | 1 | Hotplug notification strobe |
| hp_slot | input | 5 | Slot that changed |
| hp_insert | input | 1 | 1 = device added, 0 = device removed |
| sci_pulse | output | 1 | One-cycle interrupt pulse |
| eject_valid | output | 1 | One-cycle eject request |
| eject_slot | output | 5 | Slot to remove |

## Verification
The bench pays most attention to collisions in a single cycle. In one case a clearing write to status bit 1 arrives with an event; a design that let the write win would lose the notification. In another, a mask write meets an event; a design with the wrong precedence would leave stale slot bits. It also checks an enable write in the event cycle, which a design reading the next-state enable would turn into a spurious or missing pulse. On the eject side it covers a value of zero (no pulse allowed), bit 31 alone, bit 0 alone, and multi-bit values; an encoder that picked the highest bit would give the wrong slot. Byte-lane isolation is checked by clearing one status byte and confirming that the other byte and the enable register stay as they were.

// File: rtl/hpgpe_pkg.sv
package hpgpe_pkg;

    typedef enum logic [1:0] {
        WIN_GPE   = 2'd0,
        WIN_SLOT  = 2'd1,
        WIN_EJECT = 2'd2,
        WIN_NONE  = 2'd3
    } win_e;

endpackage

// File: rtl/hpgpe_event_regs.sv
module hpgpe_event_regs #(
    parameter int unsigned REG_W  = 16,
    parameter int unsigned HP_BIT = 1,
    localparam int unsigned NB    = REG_W / 8,
    localparam int unsigned AW    = $clog2(2 * NB)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    byte_addr,
    input  logic [7:0]       wdata,
    input  logic             set_hp,
    output logic [REG_W-1:0] status_q,
    output logic [REG_W-1:0] enable_q,
    output logic [7:0]       rdata
);

    typedef struct packed {
        logic [REG_W-1:0] status;
        logic [REG_W-1:0] enable;
    } ev_state_t;

    ev_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            for (int lane = 0; lane < NB; lane++) begin
                if (byte_addr == AW'(lane))
                    st_d.status[lane*8 +: 8] = st_q.status[lane*8 +: 8] & ~wdata;
                if (byte_addr == AW'(NB + lane))
                    st_d.enable[lane*8 +: 8] = wdata;
            end
        end
        // hardware set has priority over a same-cycle clear
        if (set_hp)
            st_d.status[HP_BIT] = 1'b1;
    end

    always_comb begin
        rdata = '0;
        for (int lane = 0; lane < NB; lane++) begin
            if (byte_addr == AW'(lane))
                rdata = st_q.status[lane*8 +: 8];
            if (byte_addr == AW'(NB + lane))
                rdata = st_q.enable[lane*8 +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_q = st_q.status;
    assign enable_q = st_q.enable;

endmodule

// File: rtl/hpgpe_slot_masks.sv
module hpgpe_slot_masks #(
    parameter int unsigned N_SLOTS = 32,
    localparam int unsigned SLOT_W = $clog2(N_SLOTS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_removed,
    input  logic [N_SLOTS-1:0] wdata,
    input  logic               ev_valid,
    input  logic [SLOT_W-1:0]  ev_slot,
    input  logic               ev_insert,
    output logic [N_SLOTS-1:0] inserted_q,
    output logic [N_SLOTS-1:0] removed_q
);

    typedef struct packed {
        logic [N_SLOTS-1:0] ins;
        logic [N_SLOTS-1:0] rem;
    } mask_state_t;

    mask_state_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (wr_en) begin
            if (wr_removed) m_d.rem = wdata;
            else            m_d.ins = wdata;
        end
        // an event overrides any software write in the same cycle
        if (ev_valid) begin
            m_d.ins = '0;
            m_d.rem = '0;
            if (ev_insert) m_d.ins[ev_slot] = 1'b1;
            else           m_d.rem[ev_slot] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign inserted_q = m_q.ins;
    assign removed_q  = m_q.rem;

endmodule

// File: rtl/hpgpe_eject.sv
module hpgpe_eject #(
    parameter int unsigned N_SLOTS = 32,
    localparam int unsigned SLOT_W = $clog2(N_SLOTS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [N_SLOTS-1:0] wdata,
    output logic               valid_q,
    output logic [SLOT_W-1:0]  slot_q
);

    typedef struct packed {
        logic              valid;
        logic [SLOT_W-1:0] slot;
    } ej_state_t;

    ej_state_t e_d, e_q;
    logic [SLOT_W-1:0] low_idx;

    always_comb begin
        low_idx = '0;
        for (int i = N_SLOTS - 1; i >= 0; i--) begin
            if (wdata[i]) low_idx = SLOT_W'(i);
        end
    end

    always_comb begin
        e_d       = e_q;
        e_d.valid = wr_en && (|wdata);
        if (wr_en && (|wdata)) e_d.slot = low_idx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign valid_q = e_q.valid;
    assign slot_q  = e_q.slot;

endmodule

// File: rtl/hpgpe_top.sv
module hpgpe_top
    import hpgpe_pkg::*;
#(
    parameter int unsigned GPE_W   = 16,
    parameter int unsigned N_SLOTS = 32,
    parameter int unsigned HP_BIT  = 1,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 3,
    localparam int unsigned SLOT_W = $clog2(N_SLOTS),
    localparam int unsigned GPE_NB = GPE_W / 8,
    localparam int unsigned GPE_AW = $clog2(2 * GPE_NB),
    localparam int unsigned REM_OFS = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [1:0]        bus_sel,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              hp_valid,
    input  logic [SLOT_W-1:0] hp_slot,
    input  logic              hp_insert,
    output logic              sci_pulse,
    output logic              eject_valid,
    output logic [SLOT_W-1:0] eject_slot
);

    typedef struct packed {
        logic sci;
    } top_state_t;

    win_e               win;
    logic               wr, rd;
    logic               gpe_hit, slot_hit_ins, slot_hit_rem, ej_hit;
    logic [GPE_W-1:0]   gpe_status, gpe_enable;
    logic [7:0]         gpe_rbyte;
    logic [N_SLOTS-1:0] slot_ins, slot_rem;
    top_state_t         t_d, t_q;

    always_comb begin
        win          = win_e'(bus_sel);
        wr           = bus_valid && bus_write;
        rd           = bus_valid && !bus_write;
        gpe_hit      = (win == WIN_GPE)  && (bus_addr < ADDR_W'(2 * GPE_NB));
        slot_hit_ins = (win == WIN_SLOT) && (bus_addr == '0);
        slot_hit_rem = (win == WIN_SLOT) && (bus_addr == ADDR_W'(REM_OFS));
        ej_hit       = (win == WIN_EJECT) && (bus_addr == '0);
    end

    hpgpe_event_regs #(
        .REG_W  (GPE_W),
        .HP_BIT (HP_BIT)
    ) i_event_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr && gpe_hit),
        .byte_addr (bus_addr[GPE_AW-1:0]),
        .wdata     (bus_wdata[7:0]),
        .set_hp    (hp_valid),
        .status_q  (gpe_status),
        .enable_q  (gpe_enable),
        .rdata     (gpe_rbyte)
    );

    hpgpe_slot_masks #(
        .N_SLOTS (N_SLOTS)
    ) i_slot_masks (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr && (slot_hit_ins || slot_hit_rem)),
        .wr_removed (slot_hit_rem),
        .wdata      (bus_wdata[N_SLOTS-1:0]),
        .ev_valid   (hp_valid),
        .ev_slot    (hp_slot),
        .ev_insert  (hp_insert),
        .inserted_q (slot_ins),
        .removed_q  (slot_rem)
    );

    hpgpe_eject #(
        .N_SLOTS (N_SLOTS)
    ) i_eject (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr && ej_hit),
        .wdata   (bus_wdata[N_SLOTS-1:0]),
        .valid_q (eject_valid),
        .slot_q  (eject_slot)
    );

    // interrupt uses the enable value already registered at the event
    always_comb begin
        t_d     = t_q;
        t_d.sci = hp_valid && gpe_enable[HP_BIT];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign sci_pulse = t_q.sci;

    always_comb begin
        bus_rdata = '0;
        if (rd) begin
            if (gpe_hit)      bus_rdata = DATA_W'(gpe_rbyte);
            if (slot_hit_ins) bus_rdata = DATA_W'(slot_ins);
            if (slot_hit_rem) bus_rdata = DATA_W'(slot_rem);
        end
    end

endmodule

// File: rtl/hpgpe_checker.sv
module hpgpe_checker #(
    parameter int unsigned GPE_W   = 16,
    parameter int unsigned N_SLOTS = 32,
    parameter int unsigned HP_BIT  = 1,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 3,
    localparam int unsigned SLOT_W = $clog2(N_SLOTS)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_valid,
    input logic               bus_write,
    input logic [1:0]         bus_sel,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic               hp_valid,
    input logic               hp_insert,
    input logic               sci_pulse,
    input logic               eject_valid,
    input logic [SLOT_W-1:0]  eject_slot,
    input logic [GPE_W-1:0]   status_q,
    input logic [GPE_W-1:0]   enable_q,
    input logic [N_SLOTS-1:0] inserted_q,
    input logic [N_SLOTS-1:0] removed_q
);

    logic [N_SLOTS-1:0] ej_data_q;
    logic               ej_wr;

    assign ej_wr = bus_valid && bus_write && (bus_sel == 2'd2) && (bus_addr == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) ej_data_q <= '0;
        else        ej_data_q <= bus_wdata[N_SLOTS-1:0];
    end

    assert_sci_fires_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hp_valid && enable_q[HP_BIT]) |=> sci_pulse);

    assert_sci_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sci_pulse |-> $past(hp_valid && enable_q[HP_BIT]));

    assert_hp_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hp_valid |=> status_q[HP_BIT]);

    assert_mask_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hp_valid |=> ($countones({inserted_q, removed_q}) == 1));

    assert_mask_dir_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hp_valid && hp_insert) |=> (removed_q == '0));

    assert_eject_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        eject_valid |-> $past(ej_wr && (|bus_wdata[N_SLOTS-1:0])));

    assert_eject_lowest_R9: assert property (@(posedge clk) disable iff (!rst_n)
        eject_valid |-> (ej_data_q[eject_slot] &&
                         ((ej_data_q & ~({N_SLOTS{1'b1}} << eject_slot)) == '0)));

endmodule

bind hpgpe_top hpgpe_checker #(
    .GPE_W   (GPE_W),
    .N_SLOTS (N_SLOTS),
    .HP_BIT  (HP_BIT),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W)
) i_hpgpe_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_valid   (bus_valid),
    .bus_write   (bus_write),
    .bus_sel     (bus_sel),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .hp_valid    (hp_valid),
    .hp_insert   (hp_insert),
    .sci_pulse   (sci_pulse),
    .eject_valid (eject_valid),
    .eject_slot  (eject_slot),
    .status_q    (gpe_status),
    .enable_q    (gpe_enable),
    .inserted_q  (slot_ins),
    .removed_q   (slot_rem)
);

// File: tb/test_hpgpe_top.sv
module test_hpgpe_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_valid, bus_write;
    logic [1:0]  bus_sel;
    logic [2:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        hp_valid, hp_insert;
    logic [4:0]  hp_slot;
    logic        sci_pulse, eject_valid;
    logic [4:0]  eject_slot;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic [15:0] m_st, m_en;
    logic [31:0] m_ins, m_rem;

    always #5ns clk = ~clk;

    hpgpe_top i_hpgpe_top (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_sel(bus_sel),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .hp_valid(hp_valid), .hp_slot(hp_slot), .hp_insert(hp_insert),
        .sci_pulse(sci_pulse), .eject_valid(eject_valid), .eject_slot(eject_slot)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic [1:0] sel, input logic [2:0] addr);
        logic [31:0] r = '0;
        if (sel == 2'd0) begin
            case (addr)
                3'd0: r = {24'b0, m_st[7:0]};
                3'd1: r = {24'b0, m_st[15:8]};
                3'd2: r = {24'b0, m_en[7:0]};
                3'd3: r = {24'b0, m_en[15:8]};
                default: r = '0;
            endcase
        end else if (sel == 2'd1) begin
            if (addr == 3'd0) r = m_ins;
            if (addr == 3'd4) r = m_rem;
        end
        return r;
    endfunction

    function automatic int lowest(input logic [31:0] v);
        for (int i = 31; i >= 0; i--) if (v[i]) lowest = i;
        if (v == 0) lowest = 0;
    endfunction

    task automatic model_write(input logic [1:0] sel, input logic [2:0] addr, input logic [31:0] d);
        if (sel == 2'd0) begin
            case (addr)
                3'd0: m_st[7:0]  = m_st[7:0]  & ~d[7:0];
                3'd1: m_st[15:8] = m_st[15:8] & ~d[7:0];
                3'd2: m_en[7:0]  = d[7:0];
                3'd3: m_en[15:8] = d[7:0];
                default: ;
            endcase
        end else if (sel == 2'd1) begin
            if (addr == 3'd0) m_ins = d;
            if (addr == 3'd4) m_rem = d;
        end
    endtask

    // one cycle: optional write and optional event together
    task automatic step(input bit do_wr, input logic [1:0] sel, input logic [2:0] addr,
                        input logic [31:0] d, input bit do_ev, input logic [4:0] slot,
                        input bit ins, input string tag);
        bit en_before;
        @(negedge clk);
        bus_valid = do_wr; bus_write = do_wr; bus_sel = sel; bus_addr = addr; bus_wdata = d;
        hp_valid = do_ev; hp_slot = slot; hp_insert = ins;
        en_before = m_en[1];
        if (do_wr) model_write(sel, addr, d);
        if (do_ev) begin
            m_ins = '0; m_rem = '0;
            if (ins) m_ins[slot] = 1'b1; else m_rem[slot] = 1'b1;
            m_st[1] = 1'b1;
        end
        @(negedge clk);
        check({31'b0, sci_pulse}, {31'b0, do_ev && en_before}, {tag, " R8 sci"});
        if (do_wr && sel == 2'd2) begin
            check({31'b0, eject_valid}, {31'b0, (addr == 0) && (d != 0)}, {tag, " R9 eject_valid"});
            if (addr == 0 && d != 0)
                check({27'b0, eject_slot}, 32'(lowest(d)), {tag, " R9 eject_slot"});
        end
        bus_valid = 0; bus_write = 0; hp_valid = 0;
    endtask

    task automatic rd_chk(input logic [1:0] sel, input logic [2:0] addr, input string tag);
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_sel = sel; bus_addr = addr;
        #1;
        check(bus_rdata, exp_rd(sel, addr), tag);
        bus_valid = 0;
    endtask

    task automatic rd_all(input string tag);
        rd_chk(2'd0, 3'd0, {tag, " R2 status lo"});
        rd_chk(2'd0, 3'd1, {tag, " R2 status hi"});
        rd_chk(2'd0, 3'd2, {tag, " R2 enable lo"});
        rd_chk(2'd0, 3'd3, {tag, " R2 enable hi"});
        rd_chk(2'd1, 3'd0, {tag, " R5 inserted"});
        rd_chk(2'd1, 3'd4, {tag, " R5 removed"});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0; bus_valid = 0; bus_write = 0; bus_sel = 0; bus_addr = 0; bus_wdata = 0;
        hp_valid = 0; hp_slot = 0; hp_insert = 0;
        m_st = 0; m_en = 0; m_ins = 0; m_rem = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R1 reset state
        check({30'b0, sci_pulse, eject_valid}, 32'd0, "R1 outputs idle");
        rd_all("R1 reset");

        // R5 mask read/write
        step(1, 2'd1, 3'd0, 32'hA5A5_0F0F, 0, 0, 0, "R5 wr ins");
        step(1, 2'd1, 3'd4, 32'h1234_5678, 0, 0, 0, "R5 wr rem");
        rd_all("R5");

        // R6 event clears masks, R8 no pulse with enable off
        step(0, 0, 0, 0, 1, 5'd7, 1, "R6 insert ev");
        rd_all("R6 insert");
        step(0, 0, 0, 0, 1, 5'd31, 0, "R6 remove ev");
        rd_all("R6 remove");

        // R4 enable byte writes
        step(1, 2'd0, 3'd3, 32'h0000_00C3, 0, 0, 0, "R4 en hi");
        step(1, 2'd0, 3'd2, 32'h0000_0002, 0, 0, 0, "R4 en lo");
        rd_all("R4");

        // R3 clear of high byte leaves low byte
        step(1, 2'd0, 3'd1, 32'h0000_00FF, 0, 0, 0, "R3 clr hi");
        rd_all("R3 hi");
        step(1, 2'd0, 3'd0, 32'h0000_0002, 0, 0, 0, "R3 clr lo");
        rd_all("R3 lo");

        // R8 pulse with enable on, single-cycle
        step(0, 0, 0, 0, 1, 5'd0, 1, "R8 enabled ev");
        @(negedge clk);
        check({31'b0, sci_pulse}, 32'd0, "R8 pulse one cycle");

        // R7 set wins over same-cycle clear
        step(1, 2'd0, 3'd0, 32'h0000_00FF, 1, 5'd3, 0, "R7 collide");
        rd_all("R7");

        // R8 enable cleared in event cycle still pulses (old value)
        step(1, 2'd0, 3'd2, 32'h0, 1, 5'd4, 1, "R8 en drop");
        // R8 enable set in event cycle does not pulse
        step(1, 2'd0, 3'd2, 32'h2, 1, 5'd5, 1, "R8 en raise");

        // R11 event beats mask write
        step(1, 2'd1, 3'd0, 32'hFFFF_FFFF, 1, 5'd9, 0, "R11 collide");
        rd_all("R11");

        // R9 eject corner cases
        step(1, 2'd2, 3'd0, 32'h0, 0, 0, 0, "R9 zero");
        step(1, 2'd2, 3'd0, 32'h8000_0000, 0, 0, 0, "R9 bit31");
        step(1, 2'd2, 3'd0, 32'h0000_0001, 0, 0, 0, "R9 bit0");
        step(1, 2'd2, 3'd0, 32'h0F00_00F0, 0, 0, 0, "R9 multi");
        @(negedge clk);
        check({31'b0, eject_valid}, 32'd0, "R9 pulse one cycle");

        // R10 eject reads zero; R2 unused offsets/window
        rd_chk(2'd2, 3'd0, "R10 eject read");
        step(1, 2'd0, 3'd5, 32'hFF, 0, 0, 0, "R2 unused offset wr");
        step(1, 2'd3, 3'd2, 32'hFF, 0, 0, 0, "R2 unused window wr");
        rd_chk(2'd0, 3'd6, "R2 unused offset rd");
        rd_chk(2'd3, 3'd0, "R2 unused window rd");
        rd_all("R2 after ignored");

        // constrained random
        for (int it = 0; it < 300; it++) begin
            int op;
            logic [31:0] d;
            logic [2:0]  a;
            op = $urandom_range(0, 5);
            d  = $urandom();
            case (op)
                0: step(0, 0, 0, 0, 1, 5'($urandom_range(0, 31)), 1'($urandom_range(0, 1)), "R6 rnd ev");
                1: step(1, 2'd0, 3'($urandom_range(0, 1)), d, 0, 0, 0, "R3 rnd clr");
                2: step(1, 2'd0, 3'($urandom_range(2, 3)), d, 0, 0, 0, "R4 rnd en");
                3: begin
                    a = ($urandom_range(0, 1) == 1) ? 3'd4 : 3'd0;
                    step(1, 2'd1, a, d, 1'($urandom_range(0, 1)),
                         5'($urandom_range(0, 31)), 1'($urandom_range(0, 1)), "R11 rnd mask");
                end
                4: begin
                    if ($urandom_range(0, 3) == 0) d = 32'h0;
                    step(1, 2'd2, 3'd0, d, 0, 0, 0, "R9 rnd eject");
                end
                default: step(1, 2'd0, 3'($urandom_range(0, 1)), d, 1,
                              5'($urandom_range(0, 31)), 1'($urandom_range(0, 1)), "R7 rnd mix");
            endcase
            rd_all("rnd");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule